// File: doc/BRIEF.md
# Per-Channel Burst Accumulation Buffer

This block sits between a receive framer that hands over one byte per cycle, each tagged with its channel number, and the write port of an external memory. Bytes of many channels arrive interleaved at byte granularity. Each channel owns a private on-chip slot where its bytes collect until a fixed number of them, the burst length, has arrived. The block then issues that burst to memory as a short run of wide beats, tagged with the channel and a burst address. The burst length is a parameter: it is large for dynamic memories, where each access carries a high overhead cost, and small for static memories.

Each slot holds two halves. One half keeps filling while the other waits for the memory port or drains through it. Completed bursts enter a single ready queue in the order they completed. Channels that receive more bytes complete more bursts, so they get a share of the memory port that follows their bandwidth. The framer side has no stall input. If memory backpressure lasts so long that both halves of a channel are full, further bytes for that channel are dropped and a sticky per-channel flag is raised.

Each channel writes into its own region of memory. The region is a configurable number of bursts long, and the channel's burst pointer wraps within it.

Top module: `chan_burst_packer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `wr_valid` is 0 and every `ovf` bit is 0.
- R2: A burst for a channel is requested only after BURST_BYTES bytes for it have been accepted. Its data holds those bytes in arrival order: byte i of the burst sits in beat i / MEM_BYTES, in lane i % MEM_BYTES, at bits [8*lane+7 : 8*lane].
- R3: A burst is BURST_BYTES / MEM_BYTES beats long. `wr_first` marks its first beat and `wr_last` marks its final beat, and `wr_chan` stays constant across all beats of the burst.
- R4: Bursts are issued in the order in which they completed, across all channels. A burst that is waiting is never overtaken.
- R5: `wr_addr` equals chan*REGION_BURSTS + p. Here p is the channel's burst pointer: it starts at 0, advances by one after each fully accepted burst of that channel, and wraps to 0 after reaching REGION_BURSTS-1.
- R6: A beat is accepted only in a cycle with `wr_valid` and `wr_ready` both high. While `wr_ready` is low, `wr_valid`, `wr_data`, `wr_chan` and `wr_addr` hold their values. Input bytes are accepted in every cycle regardless of `wr_ready`.
- R7: While a burst waits or drains, a channel keeps collecting bytes in its second half. A byte is dropped only when both halves of its channel are full. A dropped byte never appears in any burst, and it sets that channel's `ovf` bit, which then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A byte is presented this cycle |
| in_chan | input | CH_W | Channel of the presented byte |
| in_byte | input | 8 | Byte value |
| wr_valid | output | 1 | A write beat is presented to memory |
| wr_ready | input | 1 | Memory accepts the presented beat |
| wr_first | output | 1 | Beat is the first of its burst |
| wr_last | output | 1 | Beat is the final one of its burst |
| wr_chan | output | CH_W | Channel that owns the burst |
| wr_addr | output | ADDR_W | Burst address in burst units |
| wr_data | output | 8*MEM_BYTES | Beat data, lowest byte first |
| ovf | output | NCH | Sticky per-channel drop flags |

## Verification
A wrong fill counter or a wrong half select shows up at the first burst of the affected channel: the burst is too short or too long, its bytes are shifted, or it carries bytes of another burst. The scoreboard flags this on that burst's first beat. A lost or duplicated ready-queue entry breaks the issue order, or it makes the port go silent or repeat a burst. This is seen within a few cycles of the point where the entry should have drained. A pointer that wraps wrongly or a flag that fires too early appears on the next burst or the next check of the flags. Long stalls with both halves full exercise the drop rule directly.

// File: rtl/cbp_pkg.sv
// Shared types for the per-channel burst accumulation buffer.
package cbp_pkg;
    typedef logic [7:0] byte_t;
endpackage

// File: rtl/cbp_slots.sv
// Per-channel double-buffered byte storage.
// Each channel fills one half at a time. A filled half is reported once
// through push_* and stays full until the drain side frees it.
// Assumes at most one input byte per cycle; a byte is dropped when the
// half it would enter is still full.
module cbp_slots
    import cbp_pkg::*;
#(
    parameter int NCH = 4,
    parameter int BURST = 8,
    parameter int BPB = 4,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int CNT_W = (BURST > 1) ? $clog2(BURST) : 1,
    localparam int BEATS = BURST / BPB,
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CH_W-1:0]   in_chan,
    input  byte_t             in_byte,
    output logic              push_valid,
    output logic [CH_W-1:0]   push_ch,
    output logic              push_bk,
    input  logic              free_valid,
    input  logic [CH_W-1:0]   free_ch,
    input  logic              free_bk,
    input  logic [CH_W-1:0]   rd_ch,
    input  logic              rd_bk,
    input  logic [BEAT_W-1:0] rd_beat,
    output logic [8*BPB-1:0]  rd_data,
    output logic [NCH-1:0]    ovf
);
    byte_t            store [NCH][2][BURST];
    logic [CNT_W-1:0] cnt   [NCH];
    logic             wsel  [NCH];
    logic [1:0]       full  [NCH];

    logic drop;

    // Whether the incoming byte lands on a half that is still occupied.
    always_comb drop = in_valid && full[in_chan][wsel[in_chan]];

    // Report a half as complete on the byte that fills it.
    always_comb begin
        push_valid = in_valid && !drop && (cnt[in_chan] == CNT_W'(BURST - 1));
        push_ch    = in_chan;
        push_bk    = wsel[in_chan];
    end

    // Fill counters, half select, full flags, drop flags and byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                cnt[c]  <= '0;
                wsel[c] <= 1'b0;
                full[c] <= 2'b00;
            end
            ovf <= '0;
        end else begin
            if (free_valid) full[free_ch][free_bk] <= 1'b0;
            if (in_valid) begin
                if (drop) begin
                    ovf[in_chan] <= 1'b1;
                end else begin
                    store[in_chan][wsel[in_chan]][cnt[in_chan]] <= in_byte;
                    if (cnt[in_chan] == CNT_W'(BURST - 1)) begin
                        cnt[in_chan]                 <= '0;
                        wsel[in_chan]                <= !wsel[in_chan];
                        full[in_chan][wsel[in_chan]] <= 1'b1;
                    end else begin
                        cnt[in_chan] <= cnt[in_chan] + 1'b1;
                    end
                end
            end
        end
    end

    // Gather one memory-width beat from the half being drained.
    always_comb begin
        for (int k = 0; k < BPB; k++)
            rd_data[8*k +: 8] = store[rd_ch][rd_bk][int'(rd_beat) * BPB + k];
    end

    // R7: a raised drop flag never clears before reset.
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf != '0) |=> ((ovf & $past(ovf)) == $past(ovf)));

    // R7: the drain side only frees a half that is full.
    a_r7_free_only_full: assert property (@(posedge clk) disable iff (!rst_n)
        free_valid |-> full[free_ch][free_bk]);
endmodule

// File: rtl/cbp_rdyq.sv
// Ready queue of completed halves, kept in completion order.
// Depth covers every half of every channel, so it cannot overfill.
module cbp_rdyq #(
    parameter int W = 3,
    parameter int DEPTH = 8,
    localparam int P_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int C_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty
);
    logic [W-1:0]   slots [DEPTH];
    logic [P_W-1:0] wp, rp;
    logic [C_W-1:0] count;

    always_comb empty = (count == '0);
    always_comb head = slots[rp];

    // Circular pointers with explicit wrap and an occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) begin
                slots[wp] <= push_data;
                wp <= (wp == P_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (pop) rp <= (rp == P_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
            count <= count + C_W'(push) - C_W'(pop);
        end
    end

    // R7: every completed half finds room in the queue.
    a_r7_queue_room: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < C_W'(DEPTH)) || pop);

    // R4: never pop an empty queue.
    a_r4_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/cbp_drain.sv
// Burst drain engine. Takes the oldest completed half from the ready
// queue, presents it as BEATS beats under a valid/ready handshake, frees
// the half after the final beat and advances the channel's burst pointer.
module cbp_drain #(
    parameter int NCH = 4,
    parameter int BEATS = 2,
    parameter int REGION = 3,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int PTR_W = (REGION > 1) ? $clog2(REGION) : 1,
    localparam int ADDR_W = $clog2(NCH * REGION)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_empty,
    input  logic [CH_W:0]     q_head,
    output logic              q_pop,
    input  logic              wr_ready,
    output logic              wr_valid,
    output logic              wr_first,
    output logic              wr_last,
    output logic [CH_W-1:0]   wr_chan,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              cur_bk,
    output logic [BEAT_W-1:0] beat,
    output logic              free_valid
);
    localparam logic [ADDR_W-1:0] REG_A = ADDR_W'(REGION);

    logic             busy;
    logic [PTR_W-1:0] ptr [NCH];

    // Pull the next half whenever the port is idle.
    always_comb q_pop = !busy && !q_empty;

    // Beat presentation fields.
    always_comb begin
        wr_valid   = busy;
        wr_first   = (beat == '0);
        wr_last    = (beat == BEAT_W'(BEATS - 1));
        wr_addr    = ADDR_W'(wr_chan) * REG_A + ADDR_W'(ptr[wr_chan]);
        free_valid = busy && wr_ready && wr_last;
    end

    // Burst sequencing and per-channel address pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            beat    <= '0;
            wr_chan <= '0;
            cur_bk  <= 1'b0;
            for (int c = 0; c < NCH; c++) ptr[c] <= '0;
        end else if (q_pop) begin
            busy    <= 1'b1;
            beat    <= '0;
            wr_chan <= q_head[CH_W:1];
            cur_bk  <= q_head[0];
        end else if (busy && wr_ready) begin
            if (wr_last) begin
                busy <= 1'b0;
                ptr[wr_chan] <= (ptr[wr_chan] == PTR_W'(REGION - 1))
                                ? '0 : ptr[wr_chan] + 1'b1;
            end else begin
                beat <= beat + 1'b1;
            end
        end
    end

    // R5: the pointer in use stays inside the region.
    a_r5_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ptr[wr_chan] < PTR_W'(REGION)));

    // R3: the owning channel is held until the final beat is accepted.
    a_r3_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(wr_ready && wr_last)) |=> (busy && $stable(wr_chan)));
endmodule

// File: rtl/chan_burst_packer.sv
// Top of the per-channel burst accumulation buffer. Connects the slot
// storage, the ready queue and the drain engine. The framer side has no
// stall; memory backpressure is absorbed by the second half of each slot.
// Assumes BURST_BYTES is a multiple of MEM_BYTES and NCH >= 2.
module chan_burst_packer
    import cbp_pkg::*;
#(
    parameter int NCH = 4,
    parameter int BURST_BYTES = 8,
    parameter int MEM_BYTES = 4,
    parameter int REGION_BURSTS = 3,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int ADDR_W = $clog2(NCH * REGION_BURSTS),
    localparam int BEATS = BURST_BYTES / MEM_BYTES,
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [CH_W-1:0]        in_chan,
    input  logic [7:0]             in_byte,
    output logic                   wr_valid,
    input  logic                   wr_ready,
    output logic                   wr_first,
    output logic                   wr_last,
    output logic [CH_W-1:0]        wr_chan,
    output logic [ADDR_W-1:0]      wr_addr,
    output logic [8*MEM_BYTES-1:0] wr_data,
    output logic [NCH-1:0]         ovf
);
    logic              push_valid, push_bk;
    logic [CH_W-1:0]   push_ch;
    logic              free_valid, cur_bk;
    logic [BEAT_W-1:0] beat;
    logic              q_pop, q_empty;
    logic [CH_W:0]     q_head;

    cbp_slots #(.NCH(NCH), .BURST(BURST_BYTES), .BPB(MEM_BYTES)) slots_i (
        .clk, .rst_n, .in_valid, .in_chan, .in_byte,
        .push_valid, .push_ch, .push_bk,
        .free_valid, .free_ch(wr_chan), .free_bk(cur_bk),
        .rd_ch(wr_chan), .rd_bk(cur_bk), .rd_beat(beat),
        .rd_data(wr_data), .ovf
    );

    cbp_rdyq #(.W(CH_W + 1), .DEPTH(2 * NCH)) rdyq_i (
        .clk, .rst_n, .push(push_valid), .push_data({push_ch, push_bk}),
        .pop(q_pop), .head(q_head), .empty(q_empty)
    );

    cbp_drain #(.NCH(NCH), .BEATS(BEATS), .REGION(REGION_BURSTS)) drain_i (
        .clk, .rst_n, .q_empty, .q_head, .q_pop, .wr_ready,
        .wr_valid, .wr_first, .wr_last, .wr_chan, .wr_addr,
        .cur_bk, .beat, .free_valid
    );

    // R6: a stalled beat keeps its valid, data and address.
    a_r6_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr)));

    // R3: the beat after a final beat opens a new burst or the port is idle.
    a_r3_first_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && wr_last) |=> (!wr_valid || wr_first));
endmodule

// File: tb/chan_burst_packer_tb_top.sv
// Scoreboard bench: an arithmetic model of fill, drop, order and address.
module chan_burst_packer_tb_top;
    localparam int PERIOD = 10;
    localparam int NCH = 4, BURST = 8, MB = 4, REG = 3;
    localparam int BEATS = BURST / MB;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, wr_ready = 1'b0;
    logic [1:0] in_chan = '0;
    logic [7:0] in_byte = '0;
    logic wr_valid, wr_first, wr_last;
    logic [1:0] wr_chan;
    logic [3:0] wr_addr;
    logic [31:0] wr_data;
    logic [3:0] ovf;

    always #(PERIOD / 2) clk = ~clk;

    chan_burst_packer #(.NCH(NCH), .BURST_BYTES(BURST), .MEM_BYTES(MB),
                        .REGION_BURSTS(REG)) dut_i (
        .clk, .rst_n, .in_valid, .in_chan, .in_byte, .wr_valid, .wr_ready,
        .wr_first, .wr_last, .wr_chan, .wr_addr, .wr_data, .ovf
    );

    int total = 0, bad = 0;
    logic [63:0] acc [NCH];
    int fillc [NCH], pend [NCH], bptr [NCH];
    logic [3:0] exp_ovf = '0;
    logic [63:0] q_data [$];
    int q_ch [$], q_addr [$];
    int bidx = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check the beat, update the model.
    task automatic step(input bit v, input int ch, input bit rdy);
        logic [7:0] b = 8'($urandom);
        in_valid = v; in_chan = 2'(ch); in_byte = b; wr_ready = rdy;
        #1;
        if (wr_valid && q_data.size() == 0)
            chk(0, "R2 spurious burst", 1, 0);
        if (wr_valid && wr_ready && q_data.size() != 0) begin
            chk(wr_chan == 2'(q_ch[0]), "R4 channel order", wr_chan, q_ch[0]);
            chk(wr_addr == 4'(q_addr[0]), "R5 address", wr_addr, q_addr[0]);
            chk(wr_data == q_data[0][bidx*32 +: 32], "R2 beat data", wr_data, q_data[0][bidx*32 +: 32]);
            chk(wr_first == (bidx == 0) && wr_last == (bidx == BEATS - 1),
                "R3 first/last", {wr_first, wr_last}, {bidx == 0, bidx == BEATS - 1});
        end
        if (v) begin
            if (pend[ch] == 2) exp_ovf[ch] = 1'b1;
            else begin
                acc[ch][fillc[ch]*8 +: 8] = b;
                fillc[ch]++;
                if (fillc[ch] == BURST) begin
                    q_data.push_back(acc[ch]); q_ch.push_back(ch);
                    q_addr.push_back(ch * REG + bptr[ch]);
                    bptr[ch] = (bptr[ch] + 1) % REG;
                    pend[ch]++; fillc[ch] = 0;
                end
            end
        end
        if (wr_valid && wr_ready && q_data.size() != 0) begin
            if (bidx == BEATS - 1) begin
                pend[q_ch[0]]--; bidx = 0;
                void'(q_data.pop_front()); void'(q_ch.pop_front()); void'(q_addr.pop_front());
            end else bidx++;
        end
        @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 150000);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin acc[c] = '0; fillc[c] = 0; pend[c] = 0; bptr[c] = 0; end
        repeat (3) @(negedge clk);
        chk(wr_valid == 1'b0 && ovf == 4'b0, "R1 reset state", {wr_valid, ovf}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_valid == 1'b0 && ovf == 4'b0, "R1 after reset", {wr_valid, ovf}, 0);
        // R2: seven bytes produce no burst, the eighth completes one.
        for (int i = 0; i < 7; i++) step(1, 0, 1);
        chk(wr_valid == 1'b0, "R2 partial burst held", wr_valid, 0);
        for (int i = 0; i < 9; i++) step(1, 0, 1);
        repeat (20) step(0, 0, 1);
        // R4/R5: byte-interleaved round robin, pointers wrap twice.
        for (int i = 0; i < NCH * BURST * 7; i++) step(1, i % NCH, 1);
        repeat (30) step(0, 0, 1);
        // R6: random channels with random memory stalls.
        for (int i = 0; i < 3000; i++) step(($urandom % 5) != 0, int'($urandom % NCH), ($urandom % 5) < 3);
        repeat (60) step(0, 0, 1);
        chk(ovf == exp_ovf, "R7 flags after random", ovf, exp_ovf);
        // R7: long stall fills both halves of channel 2, then bytes drop.
        for (int i = 0; i < 30; i++) step(1, 2, 0);
        for (int i = 0; i < 8; i++) step(1, 1, 0);
        chk(exp_ovf[2] == 1'b1, "R7 model expects drop", exp_ovf, 4'b0100);
        chk(ovf == exp_ovf, "R7 drop flag", ovf, exp_ovf);
        repeat (60) step(0, 0, 1);
        chk(ovf == exp_ovf, "R7 flag sticky", ovf, exp_ovf);
        // R7: channel 2 refills normally after draining.
        for (int i = 0; i < 8; i++) step(1, 2, 1);
        repeat (20) step(0, 0, 1);
        chk(q_data.size() == 0 && wr_valid == 1'b0, "R4 all bursts drained",
            q_data.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule